// File: doc/BRIEF.md
# Virtually Tagged Cache Lookup with Address-Space Identifiers

This block is the tag-and-data lookup stage of a set-associative cache that works purely on virtual addresses. A requester presents a virtual address together with the identifier of the address space it belongs to. The block answers with hit or miss and, on a hit, the addressed 32-bit word of the cached line. No translated address is ever needed, so the lookup is never held up by address translation.

Every stored line carries the address-space identifier of the space that filled it. When identifier matching is enabled, the same virtual address issued from a different space lands in the same set but misses, so a homonym can never return another space's data. When identifier matching is disabled, only the virtual tag is compared. In that mode a whole-cache flush, pulsed whenever the active page table changes, is what keeps stale mappings out. Lines are installed by fill commands that carry the virtual address, the identifier and the whole line.

The geometry is set by parameters. The number of sets, the number of ways and the line size in bytes must be powers of two. There must be at least two sets and two ways, and a line holds at least two 32-bit words. Capacity is the line size multiplied by the set count and the way count.

Top module: `vcache_asid`

## Requirements
- R1: The virtual address is divided from the least significant bit upward. The low log2(LINE_BYTES) bits are the line offset, and within them bits [1:0] choose a byte and are ignored. Bits [log2(LINE_BYTES)-1:2] choose the word. The next log2(SETS) bits choose the set, and the remaining upper bits form the tag.
- R2: `rsp_vld` is high in exactly the cycle after a cycle in which `lkp_req` was high, and low otherwise.
- R3: A lookup hits when a valid way of the selected set holds the same tag and, with `asid_match_en`=1, the same identifier. On a hit `rsp_data` is word k of that way's line, where word k occupies bits [32k+31:32k] of `fill_line`.
- R4: With `asid_match_en`=1, a lookup whose tag is resident but whose identifier differs from the stored one misses.
- R5: With `asid_match_en`=0, the identifier is ignored in the comparison, and a resident tag hits whatever identifier is presented.
- R6: A `flush` pulse invalidates every way at the next clock edge. A lookup issued the cycle after the flush misses. A fill presented in the same cycle as a flush is dropped.
- R7: After reset every way is invalid, and `rsp_vld`, `rsp_hit` and `rsp_data` are 0.
- R8: A fill of a line that is not resident goes into the lowest-numbered invalid way of its set.
- R9: When every way of the set is valid, a fill of a non-resident line replaces the way named by that set's round-robin pointer. The pointer starts at way 0 after reset or flush and advances by one, wrapping, on each such replacement only.
- R10: A fill whose tag (and identifier, when matching is enabled) is already resident in the set rewrites that same way. It does not move the round-robin pointer.
- R11: `rsp_data` is 0 whenever the response is a miss.
- R12: A lookup and a fill in the same cycle: the lookup sees the contents as they were before the fill.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| asid_match_en | input | 1 | 1: compare identifiers as part of the tag; 0: virtual tag only |
| flush | input | 1 | Invalidate every way |
| lkp_req | input | 1 | Lookup request |
| lkp_va | input | VA_W | Lookup virtual address |
| lkp_asid | input | ASID_W | Lookup address-space identifier |
| fill_req | input | 1 | Install a line |
| fill_va | input | VA_W | Virtual address of the line being installed |
| fill_asid | input | ASID_W | Identifier stored with the installed line |
| fill_line | input | 8*LINE_BYTES | Line data, word 0 in the low bits |
| rsp_vld | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_data | output | 32 | Selected word on a hit, 0 on a miss |

## Verification
The assertions assume that `lkp_va`, `lkp_asid`, `fill_va` and `fill_asid` hold known values in every cycle where their request is high. They also assume `flush` is a plain pulse, with no assumption about how it lines up with other commands. The bench changes all inputs only on the falling edge and keeps every address within the configured width. It issues fills and lookups as single-cycle commands, except in the sequences that deliberately overlap a fill with a lookup or with a flush. Expected results come from a bench-side model of valid bits, tags, identifiers, lines and per-set pointers, updated from the requirement rules alone.

// File: rtl/vc_pkg.sv
package vc_pkg;
  localparam int VC_WORD_W     = 32;
  localparam int VC_WORD_BYTES = VC_WORD_W / 8;

  typedef enum logic [1:0] {
    VIC_RR   = 2'd0,
    VIC_FREE = 2'd1,
    VIC_HIT  = 2'd2
  } vic_src_e;
endpackage

// File: rtl/vc_addr_split.sv
module vc_addr_split #(
  parameter int VA_W       = 48,
  parameter int SETS       = 16,
  parameter int LINE_BYTES = 32,
  localparam int BYTE_W    = $clog2(vc_pkg::VC_WORD_BYTES),
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int WSEL_W    = OFF_W - BYTE_W,
  localparam int IDX_W     = $clog2(SETS),
  localparam int TAG_W     = VA_W - OFF_W - IDX_W
) (
  input  logic [VA_W-1:0]   va_i,
  output logic [TAG_W-1:0]  tag_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [WSEL_W-1:0] wsel_o
);
  logic [BYTE_W-1:0] byte_unused;

  assign byte_unused = va_i[BYTE_W-1:0];
  assign wsel_o      = va_i[OFF_W-1:BYTE_W];
  assign idx_o       = va_i[OFF_W+IDX_W-1:OFF_W];
  assign tag_o       = va_i[VA_W-1:OFF_W+IDX_W];
endmodule

// File: rtl/vc_tag_array.sv
module vc_tag_array
  import vc_pkg::*;
#(
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  parameter int TAG_W  = 39,
  parameter int ASID_W = 16,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              asid_en_i,
  input  logic [IDX_W-1:0]  lk_idx_i,
  input  logic [TAG_W-1:0]  lk_tag_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  output logic [WAYS-1:0]   lk_hit_o,
  input  logic              fl_req_i,
  input  logic [IDX_W-1:0]  fl_idx_i,
  input  logic [TAG_W-1:0]  fl_tag_i,
  input  logic [ASID_W-1:0] fl_asid_i,
  output logic              fl_we_o,
  output logic [WAY_W-1:0]  fl_way_o
);
  logic [WAYS-1:0]   valid_q [SETS];
  logic [WAYS-1:0]   valid_d [SETS];
  logic [WAY_W-1:0]  rr_q    [SETS];
  logic [WAY_W-1:0]  rr_d    [SETS];
  logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
  logic [ASID_W-1:0] asid_q  [SETS][WAYS];
  logic [WAYS-1:0]   fl_match;
  vic_src_e          vic_src;

  // parallel compare of every way in the addressed set, for both ports
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign lk_hit_o[w] = valid_q[lk_idx_i][w]
                      && (tag_q[lk_idx_i][w] == lk_tag_i)
                      && (!asid_en_i || (asid_q[lk_idx_i][w] == lk_asid_i));
    assign fl_match[w] = valid_q[fl_idx_i][w]
                      && (tag_q[fl_idx_i][w] == fl_tag_i)
                      && (!asid_en_i || (asid_q[fl_idx_i][w] == fl_asid_i));
  end

  assign fl_we_o = fl_req_i && !flush_i;

  // victim choice: resident way, else lowest free way, else round robin
  always_comb begin
    vic_src  = VIC_RR;
    fl_way_o = rr_q[fl_idx_i];
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_q[fl_idx_i][w]) begin
        vic_src  = VIC_FREE;
        fl_way_o = WAY_W'(w);
      end
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (fl_match[w]) begin
        vic_src  = VIC_HIT;
        fl_way_o = WAY_W'(w);
      end
    end
  end

  // next state of valid bits and round-robin pointers
  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      valid_d[s] = valid_q[s];
      rr_d[s]    = rr_q[s];
    end
    if (flush_i) begin
      for (int s = 0; s < SETS; s++) begin
        valid_d[s] = '0;
        rr_d[s]    = '0;
      end
    end else if (fl_we_o) begin
      valid_d[fl_idx_i][fl_way_o] = 1'b1;
      if (vic_src == VIC_RR) begin
        rr_d[fl_idx_i] = rr_q[fl_idx_i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        rr_q[s]    <= '0;
      end
    end else begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= valid_d[s];
        rr_q[s]    <= rr_d[s];
      end
    end
  end

  // tag and identifier storage, write-enabled, no reset needed
  always_ff @(posedge clk) begin
    if (fl_we_o) begin
      tag_q[fl_idx_i][fl_way_o]  <= fl_tag_i;
      asid_q[fl_idx_i][fl_way_o] <= fl_asid_i;
    end
  end
endmodule

// File: rtl/vc_data_array.sv
module vc_data_array #(
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  parameter int LINE_W = 256,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                         clk,
  input  logic                         we_i,
  input  logic [IDX_W-1:0]             wr_idx_i,
  input  logic [WAY_W-1:0]             wr_way_i,
  input  logic [LINE_W-1:0]            wr_line_i,
  input  logic [IDX_W-1:0]             rd_idx_i,
  output logic [WAYS-1:0][LINE_W-1:0]  rd_lines_o
);
  logic [LINE_W-1:0] line_q [SETS][WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    assign rd_lines_o[w] = line_q[rd_idx_i][w];
  end

  always_ff @(posedge clk) begin
    if (we_i) begin
      line_q[wr_idx_i][wr_way_i] <= wr_line_i;
    end
  end
endmodule

// File: rtl/vcache_asid.sv
module vcache_asid
  import vc_pkg::*;
#(
  parameter int VA_W       = 48,
  parameter int ASID_W     = 16,
  parameter int SETS       = 16,
  parameter int WAYS       = 4,
  parameter int LINE_BYTES = 32,
  localparam int LINE_W    = LINE_BYTES * 8,
  localparam int WORDS     = LINE_BYTES / VC_WORD_BYTES,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int WSEL_W    = $clog2(WORDS),
  localparam int IDX_W     = $clog2(SETS),
  localparam int WAY_W     = $clog2(WAYS),
  localparam int TAG_W     = VA_W - OFF_W - IDX_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 asid_match_en,
  input  logic                 flush,
  input  logic                 lkp_req,
  input  logic [VA_W-1:0]      lkp_va,
  input  logic [ASID_W-1:0]    lkp_asid,
  input  logic                 fill_req,
  input  logic [VA_W-1:0]      fill_va,
  input  logic [ASID_W-1:0]    fill_asid,
  input  logic [LINE_W-1:0]    fill_line,
  output logic                 rsp_vld,
  output logic                 rsp_hit,
  output logic [VC_WORD_W-1:0] rsp_data
);
  logic [TAG_W-1:0]               lk_tag, fl_tag;
  logic [IDX_W-1:0]               lk_idx, fl_idx;
  logic [WSEL_W-1:0]              lk_wsel, fl_wsel_unused;
  logic [WAYS-1:0]                hit_vec;
  logic                           fl_we;
  logic [WAY_W-1:0]               fl_way;
  logic [WAYS-1:0][LINE_W-1:0]    set_lines;
  logic [WAY_W-1:0]               hit_way;
  logic [WORDS-1:0][VC_WORD_W-1:0] line_words;
  logic                           vld_d, hit_d;
  logic [VC_WORD_W-1:0]           data_d;
  logic                           vld_q, hit_q;
  logic [VC_WORD_W-1:0]           data_q;

  vc_addr_split #(.VA_W(VA_W), .SETS(SETS), .LINE_BYTES(LINE_BYTES)) u_lk_split (
    .va_i(lkp_va), .tag_o(lk_tag), .idx_o(lk_idx), .wsel_o(lk_wsel)
  );

  vc_addr_split #(.VA_W(VA_W), .SETS(SETS), .LINE_BYTES(LINE_BYTES)) u_fl_split (
    .va_i(fill_va), .tag_o(fl_tag), .idx_o(fl_idx), .wsel_o(fl_wsel_unused)
  );

  vc_tag_array #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .ASID_W(ASID_W)) u_tags (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush_i   (flush),
    .asid_en_i (asid_match_en),
    .lk_idx_i  (lk_idx),
    .lk_tag_i  (lk_tag),
    .lk_asid_i (lkp_asid),
    .lk_hit_o  (hit_vec),
    .fl_req_i  (fill_req),
    .fl_idx_i  (fl_idx),
    .fl_tag_i  (fl_tag),
    .fl_asid_i (fill_asid),
    .fl_we_o   (fl_we),
    .fl_way_o  (fl_way)
  );

  vc_data_array #(.SETS(SETS), .WAYS(WAYS), .LINE_W(LINE_W)) u_data (
    .clk        (clk),
    .we_i       (fl_we),
    .wr_idx_i   (fl_idx),
    .wr_way_i   (fl_way),
    .wr_line_i  (fill_line),
    .rd_idx_i   (lk_idx),
    .rd_lines_o (set_lines)
  );

  // lowest matching way wins if several match (possible with matching off)
  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end

  assign line_words = set_lines[hit_way];

  always_comb begin
    vld_d  = lkp_req;
    hit_d  = lkp_req && (|hit_vec);
    data_d = hit_d ? line_words[lk_wsel] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      hit_q  <= 1'b0;
      data_q <= '0;
    end else begin
      vld_q  <= vld_d;
      hit_q  <= hit_d;
      data_q <= data_d;
    end
  end

  assign rsp_vld  = vld_q;
  assign rsp_hit  = hit_q;
  assign rsp_data = data_q;
endmodule

// File: rtl/vc_lookup_chk.sv
module vc_lookup_chk #(
  parameter int VA_W       = 48,
  parameter int ASID_W     = 16,
  parameter int LINE_BYTES = 32,
  localparam int OFF_W     = $clog2(LINE_BYTES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              lkp_req,
  input logic [VA_W-1:0]   lkp_va,
  input logic [ASID_W-1:0] lkp_asid,
  input logic              fill_req,
  input logic [VA_W-1:0]   fill_va,
  input logic [ASID_W-1:0] fill_asid,
  input logic              rsp_vld,
  input logic              rsp_hit
);
  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_req |=> rsp_vld);                                                // R2

  AST_NO_RSP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !lkp_req |=> !rsp_vld);                                              // R2

  AST_FLUSH_THEN_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    flush ##1 lkp_req |=> !rsp_hit);                                     // R6

  AST_FILL_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req && !flush) ##1
    (lkp_req && (lkp_va[VA_W-1:OFF_W] == $past(fill_va[VA_W-1:OFF_W]))
             && (lkp_asid == $past(fill_asid)))
    |=> rsp_hit);                                                        // R3
endmodule

bind vcache_asid vc_lookup_chk #(
  .VA_W(VA_W), .ASID_W(ASID_W), .LINE_BYTES(LINE_BYTES)
) u_lookup_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .lkp_req(lkp_req),
  .lkp_va(lkp_va), .lkp_asid(lkp_asid), .fill_req(fill_req),
  .fill_va(fill_va), .fill_asid(fill_asid), .rsp_vld(rsp_vld),
  .rsp_hit(rsp_hit)
);

// File: tb/tb_vcache_asid.sv
module tb_vcache_asid;
  localparam int CLK_PERIOD = 10;
  localparam int VA_W   = 12;
  localparam int ASID_W = 2;
  localparam int SETS   = 4;
  localparam int WAYS   = 4;
  localparam int LINE_BYTES = 16;
  localparam int LINE_W = LINE_BYTES * 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              asid_match_en = 1'b1;
  logic              flush = 1'b0;
  logic              lkp_req = 1'b0;
  logic [VA_W-1:0]   lkp_va = '0;
  logic [ASID_W-1:0] lkp_asid = '0;
  logic              fill_req = 1'b0;
  logic [VA_W-1:0]   fill_va = '0;
  logic [ASID_W-1:0] fill_asid = '0;
  logic [LINE_W-1:0] fill_line = '0;
  logic              rsp_vld, rsp_hit;
  logic [31:0]       rsp_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference model
  bit          m_v    [SETS][WAYS];
  int          m_tag  [SETS][WAYS];
  int          m_asid [SETS][WAYS];
  logic [LINE_W-1:0] m_line [SETS][WAYS];
  int          m_rr   [SETS];

  always #(CLK_PERIOD/2) clk = ~clk;

  vcache_asid #(.VA_W(VA_W), .ASID_W(ASID_W), .SETS(SETS), .WAYS(WAYS),
                .LINE_BYTES(LINE_BYTES)) dut (
    .clk(clk), .rst_n(rst_n), .asid_match_en(asid_match_en), .flush(flush),
    .lkp_req(lkp_req), .lkp_va(lkp_va), .lkp_asid(lkp_asid),
    .fill_req(fill_req), .fill_va(fill_va), .fill_asid(fill_asid),
    .fill_line(fill_line), .rsp_vld(rsp_vld), .rsp_hit(rsp_hit),
    .rsp_data(rsp_data)
  );

  function automatic logic [VA_W-1:0] mk_va(int tag, int set, int word, int byt);
    return VA_W'((tag << 6) | (set << 4) | (word << 2) | byt);
  endfunction

  function automatic logic [LINE_W-1:0] mk_line(int seed);
    logic [LINE_W-1:0] l;
    for (int i = 0; i < 4; i++) l[32*i +: 32] = 32'((seed << 12) | (i << 8) | (seed & 8'hff));
    return l;
  endfunction

  function automatic int m_find(int set, int tag, int asid);
    for (int w = 0; w < WAYS; w++)
      if (m_v[set][w] && m_tag[set][w] == tag && (!asid_match_en || m_asid[set][w] == asid))
        return w;
    return -1;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic m_flush();
    for (int s = 0; s < SETS; s++) begin
      m_rr[s] = 0;
      for (int w = 0; w < WAYS; w++) m_v[s][w] = 1'b0;
    end
  endtask

  task automatic m_fill(int tag, int set, int asid, logic [LINE_W-1:0] line);
    int w;
    w = m_find(set, tag, asid);
    if (w < 0) begin
      for (int k = WAYS - 1; k >= 0; k--) if (!m_v[set][k]) w = k;
    end
    if (w < 0) begin
      w = m_rr[set];
      m_rr[set] = (m_rr[set] + 1) % WAYS;
    end
    m_v[set][w] = 1'b1; m_tag[set][w] = tag; m_asid[set][w] = asid; m_line[set][w] = line;
  endtask

  task automatic do_fill(int tag, int set, int asid, int seed);
    @(negedge clk);
    fill_req = 1'b1; fill_va = mk_va(tag, set, 0, 0);
    fill_asid = ASID_W'(asid); fill_line = mk_line(seed);
    @(negedge clk);
    fill_req = 1'b0;
    m_fill(tag, set, asid, mk_line(seed));
  endtask

  task automatic do_lookup(int tag, int set, int word, int byt, int asid, string req);
    int w;
    bit exp_hit;
    logic [31:0] exp_data;
    w = m_find(set, tag, asid);
    exp_hit = (w >= 0);
    exp_data = exp_hit ? m_line[set][w][32*word +: 32] : 32'h0;
    @(negedge clk);
    lkp_req = 1'b1; lkp_va = mk_va(tag, set, word, byt); lkp_asid = ASID_W'(asid);
    @(negedge clk);
    lkp_req = 1'b0;
    check(rsp_vld == 1'b1, "R2", "rsp_vld", rsp_vld, 1);
    check(rsp_hit == exp_hit, req, "rsp_hit", rsp_hit, exp_hit);
    check(rsp_data == exp_data, exp_hit ? "R1" : "R11", "rsp_data", rsp_data, exp_data);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    m_flush();
    repeat (3) @(negedge clk);
    // R7: reset state
    check(rsp_vld == 0 && rsp_hit == 0 && rsp_data == 0, "R7", "reset outputs",
          {rsp_vld, rsp_hit, rsp_data}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_vld == 1'b0, "R2", "idle rsp_vld", rsp_vld, 0);
    for (int s = 0; s < SETS; s++) do_lookup(1, s, 0, 0, 0, "R7");

    // R8 then R9: six fills per set, four free ways then two replacements
    for (int s = 0; s < SETS; s++) begin
      for (int k = 0; k < 6; k++) do_fill(k + 1 + 8 * s, s, k % 4, 16 * s + k + 1);
      for (int k = 0; k < 6; k++)
        for (int wd = 0; wd < 4; wd++) do_lookup(k + 1 + 8 * s, s, wd, wd, k % 4, k < 2 ? "R9" : "R8");
    end
    // R1: upper tag bits distinguish lines sharing low tag bits
    do_lookup(3 + 32, 0, 1, 0, 2, "R1");

    // R4: resident tags, wrong identifier
    for (int s = 0; s < SETS; s++)
      for (int k = 2; k < 6; k++) do_lookup(k + 1 + 8 * s, s, 2, 0, (k + 1) % 4, "R4");

    // R5: identifier ignored
    asid_match_en = 1'b0;
    for (int s = 0; s < SETS; s++)
      for (int k = 2; k < 6; k++) do_lookup(k + 1 + 8 * s, s, 3, 1, (k + 1) % 4, "R5");
    asid_match_en = 1'b1;

    // R10: refill of a resident line rewrites it, pointer unmoved
    do_fill(5, 0, 0, 200);
    for (int wd = 0; wd < 4; wd++) do_lookup(5, 0, wd, 0, 0, "R10");
    do_fill(20, 0, 1, 201);
    for (int k = 0; k < 6; k++) do_lookup(k + 1, 0, 0, 0, k % 4, "R10");
    do_lookup(20, 0, 2, 0, 1, "R9");

    // R12: lookup and fill of the same line in one cycle
    @(negedge clk);
    fill_req = 1'b1; fill_va = mk_va(40, 2, 0, 0); fill_asid = 2'd0; fill_line = mk_line(300);
    lkp_req = 1'b1; lkp_va = mk_va(40, 2, 1, 0); lkp_asid = 2'd0;
    @(negedge clk);
    fill_req = 1'b0; lkp_req = 1'b0;
    check(rsp_hit == 1'b0, "R12", "same-cycle lookup", rsp_hit, 0);
    m_fill(40, 2, 0, mk_line(300));
    do_lookup(40, 2, 1, 0, 0, "R12");

    // R6: flush, then every line misses
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    m_flush();
    for (int s = 0; s < SETS; s++)
      for (int k = 2; k < 6; k++) do_lookup(k + 1 + 8 * s, s, 0, 0, k % 4, "R6");
    // R6: fill together with flush is dropped
    @(negedge clk);
    flush = 1'b1; fill_req = 1'b1; fill_va = mk_va(50, 1, 0, 0); fill_asid = 2'd3;
    fill_line = mk_line(400);
    @(negedge clk);
    flush = 1'b0; fill_req = 1'b0;
    m_flush();
    do_lookup(50, 1, 0, 0, 3, "R6");
    // R9: pointer restarts at way 0 after flush
    for (int k = 0; k < 7; k++) do_fill(k + 10, 3, 0, 500 + k);
    for (int k = 0; k < 7; k++) do_lookup(k + 10, 3, 3, 0, 0, "R9");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule